// File: doc/BRIEF.md
# Delay-Locked Loop and Pad Calibration Sequencer

This block sequences the bring-up of a delay-locked loop and the impedance calibration of the I/O pads that depend on it. Software-side control arrives as single-cycle command pulses (loop on, loop off, start calibration). The sequencer waits for the loop to report lock. It then powers the analog calibration cell and holds a programmable warm-up delay. After that it raises a request to the cell and captures the P and N drive codes the cell returns with its acknowledge. While the cell is powered, a one-cycle strobe paced by a 3-bit divider clocks it.

Several options sit on top of this sequence. A keep-powered option leaves the analog path on after a successful run, so later runs go straight to the request without a warm-up. A free-running interval counter re-launches calibration periodically and raises a sticky done flag when such a run finishes. A force option replaces the captured codes with fixed values. A 16-bit watchdog aborts a run whose lock wait or acknowledge wait lasts too long and raises a sticky timeout flag. The loop and the analog cell are modelled only as request, acknowledge and lock pins. No data stream crosses this block, so every pin is plain control or status.

Top module: `dll_cal_seq`

## Requirements
- R1: While reset is held and on the first cycle after it, dll_enable, cal_power, cal_req, cal_clk_pulse, stat_locked, stat_cal_busy, stat_refresh_done and stat_timeout are all 0, and code_p and code_n are 0.
- R2: dll_enable is 1 in the cycle after a cmd_dll_on pulse. cmd_dll_off wins over cmd_dll_on in the same cycle. stat_locked is dll_enable AND dll_lock registered once. In the cycle after cmd_dll_off, dll_enable, stat_locked, cal_power, cal_req and stat_cal_busy are all 0, which aborts any calibration in progress.
- R3: cmd_dll_on and cmd_start_cal may arrive in the same cycle. The sequencer then holds stat_cal_busy and waits for stat_locked before the warm-up. Bring-up is complete when stat_locked is 1 and stat_cal_busy is 0.
- R4: stat_cal_busy rises in the cycle after a start. If cal_power is 0 and stat_locked is already 1, cal_req rises exactly cfg_warm_cycles+2 cycles after stat_cal_busy rises: one lock-check cycle plus cfg_warm_cycles+1 warm-up cycles with cal_power high.
- R5: With cfg_keep_powered=1, cal_power stays 1 after a successful run, and the next run raises cal_req one cycle after stat_cal_busy. With cfg_keep_powered=0, cal_power is 0 once stat_cal_busy falls.
- R6: While cal_power is 1 and cfg_clk_div is steady, cal_clk_pulse is a one-cycle strobe that repeats every cfg_clk_div+1 cycles. It is never 1 while cal_power is 0.
- R7: cal_p_in and cal_n_in are captured in the cycle where cal_req and cal_ack are both 1. stat_cal_busy and cal_req fall in the next cycle, and code_p/code_n then show the captured values.
- R8: While cfg_force_codes is 1, code_p and code_n equal cfg_force_p and cfg_force_n. When it returns to 0, they show the last captured values again.
- R9: With cfg_refresh_period=N>0, after at least one successful run and with stat_locked=1, a new run starts after exactly N idle cycles (stat_cal_busy low for N cycles). N=0 never starts a run.
- R10: stat_refresh_done becomes 1 when a run launched by the refresh counter completes successfully. A run started by cmd_start_cal never sets it. A stat_rd pulse clears it, and a set in the same cycle wins.
- R11: With cfg_timeout=T>0, a run stuck waiting for lock (or for cal_ack) for T cycles returns to idle. When stuck in the lock wait, stat_cal_busy stays high for exactly T cycles. stat_timeout is set at the same edge, stays set, and is cleared by stat_rd. T=0 disables the watchdog.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_dll_on | input | 1 | Pulse: enable the delay-locked loop |
| cmd_dll_off | input | 1 | Pulse: disable the loop, abort calibration |
| cmd_start_cal | input | 1 | Pulse: start a calibration run |
| cfg_keep_powered | input | 1 | Leave the analog cell powered after a run |
| cfg_clk_div | input | 3 | Calibration strobe divider (period = value+1) |
| cfg_warm_cycles | input | 9 | Warm-up delay before the request |
| cfg_refresh_period | input | 32 | Idle cycles between periodic runs, 0 = off |
| cfg_force_codes | input | 1 | Override output codes with fixed values |
| cfg_force_p | input | 4 | Forced P code |
| cfg_force_n | input | 4 | Forced N code |
| cfg_timeout | input | 16 | Wait limit in cycles, 0 = off |
| stat_rd | input | 1 | Pulse: status read, clears sticky flags |
| dll_enable | output | 1 | Enable to the delay-locked loop |
| dll_lock | input | 1 | Lock indication from the loop |
| cal_power | output | 1 | Power enable to the analog calibration cell |
| cal_clk_pulse | output | 1 | Divided strobe clocking the cell |
| cal_req | output | 1 | Calibration request to the cell |
| cal_ack | input | 1 | Cell acknowledge, codes valid |
| cal_p_in | input | 4 | P code from the cell |
| cal_n_in | input | 4 | N code from the cell |
| code_p | output | 4 | P drive code in use |
| code_n | output | 4 | N drive code in use |
| stat_locked | output | 1 | Loop locked |
| stat_cal_busy | output | 1 | Calibration run in progress |
| stat_refresh_done | output | 1 | Sticky: a periodic run completed |
| stat_timeout | output | 1 | Sticky: a run was aborted by the watchdog |

## Verification
The bench builds the block with its default widths: a 3-bit divider, a 9-bit warm-up count, a 32-bit refresh interval and a 16-bit watchdog. It programs these widths only with small values: warm-up delays up to 40, refresh intervals of a few dozen cycles, and a watchdog limit of 25. This makes exact cycle counts of the warm-up window, the refresh idle gap and the watchdog abort practical within a short run. Every divider setting from 0 to 7 is reachable, so all strobe periods are measured, including the every-cycle case.

// File: rtl/dcs_pkg.sv
package dcs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LOCKW = 2'd1,
    ST_WARM  = 2'd2,
    ST_REQ   = 2'd3
  } cal_state_t;
endpackage

// File: rtl/dcs_clkdiv.sv
module dcs_clkdiv #(
  parameter int DIV_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] div,
  output logic             pulse
);
  logic [DIV_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt_q <= '0;
    else if (!en || cnt_q >= div) cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end

  assign pulse = en && (cnt_q == div);

  // R6
  strobe_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse && div != '0) |=> (!pulse || div == '0));
endmodule

// File: rtl/dcs_interval.sv
module dcs_interval #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         clr,
  input  logic [W-1:0] limit,
  output logic         hit
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};
  logic [W-1:0] cnt_q;

  assign hit = run && (limit != '0) && (cnt_q == limit - ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt_q <= '0;
    else if (clr || !run || hit) cnt_q <= '0;
    else                        cnt_q <= cnt_q + ONE;
  end
endmodule

// File: rtl/dll_cal_seq.sv
module dll_cal_seq
  import dcs_pkg::*;
#(
  parameter int DIV_W  = 3,
  parameter int WARM_W = 9,
  parameter int REF_W  = 32,
  parameter int TOUT_W = 16,
  parameter int CODE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_dll_on,
  input  logic              cmd_dll_off,
  input  logic              cmd_start_cal,
  input  logic              cfg_keep_powered,
  input  logic [DIV_W-1:0]  cfg_clk_div,
  input  logic [WARM_W-1:0] cfg_warm_cycles,
  input  logic [REF_W-1:0]  cfg_refresh_period,
  input  logic              cfg_force_codes,
  input  logic [CODE_W-1:0] cfg_force_p,
  input  logic [CODE_W-1:0] cfg_force_n,
  input  logic [TOUT_W-1:0] cfg_timeout,
  input  logic              stat_rd,
  output logic              dll_enable,
  input  logic              dll_lock,
  output logic              cal_power,
  output logic              cal_clk_pulse,
  output logic              cal_req,
  input  logic              cal_ack,
  input  logic [CODE_W-1:0] cal_p_in,
  input  logic [CODE_W-1:0] cal_n_in,
  output logic [CODE_W-1:0] code_p,
  output logic [CODE_W-1:0] code_n,
  output logic              stat_locked,
  output logic              stat_cal_busy,
  output logic              stat_refresh_done,
  output logic              stat_timeout
);
  cal_state_t        state_q, state_d;
  logic [WARM_W-1:0] warm_q, warm_d;
  logic              dll_en_q, dll_en_d;
  logic              locked_q;
  logic              power_q, power_d;
  logic              calibrated_q, by_ref_q;
  logic              done_q, tout_q;
  logic [CODE_W-1:0] p_q, n_q;
  logic              ref_hit, t_exp, abort_c, cal_ok, waiting, ref_run;

  // loop enable: off wins
  always_comb begin
    dll_en_d = dll_en_q;
    if (cmd_dll_on)  dll_en_d = 1'b1;
    if (cmd_dll_off) dll_en_d = 1'b0;
  end

  assign waiting = (state_q == ST_LOCKW) || (state_q == ST_REQ);
  assign ref_run = (state_q == ST_IDLE) && calibrated_q && locked_q;

  dcs_interval #(.W(REF_W)) u_refresh (
    .clk(clk), .rst_n(rst_n), .run(ref_run), .clr(1'b0),
    .limit(cfg_refresh_period), .hit(ref_hit)
  );

  dcs_interval #(.W(TOUT_W)) u_watchdog (
    .clk(clk), .rst_n(rst_n), .run(waiting), .clr(state_q != state_d),
    .limit(cfg_timeout), .hit(t_exp)
  );

  dcs_clkdiv #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .en(power_q), .div(cfg_clk_div),
    .pulse(cal_clk_pulse)
  );

  // sequencer
  always_comb begin
    state_d = state_q;
    warm_d  = warm_q;
    abort_c = 1'b0;
    unique case (state_q)
      ST_IDLE: if (cmd_start_cal || ref_hit) state_d = ST_LOCKW;
      ST_LOCKW: begin
        if (locked_q) begin
          if (power_q) state_d = ST_REQ;
          else begin
            state_d = ST_WARM;
            warm_d  = cfg_warm_cycles;
          end
        end else if (t_exp) begin
          state_d = ST_IDLE;
          abort_c = 1'b1;
        end
      end
      ST_WARM: begin
        if (warm_q == '0) state_d = ST_REQ;
        else              warm_d  = warm_q - 1'b1;
      end
      ST_REQ: begin
        if (cal_ack) state_d = ST_IDLE;
        else if (t_exp) begin
          state_d = ST_IDLE;
          abort_c = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
    if (cmd_dll_off) state_d = ST_IDLE;
  end

  assign cal_ok = (state_q == ST_REQ) && cal_ack && !cmd_dll_off;

  always_comb begin
    power_d = power_q;
    if (cmd_dll_off)                 power_d = 1'b0;
    else if (state_d == ST_WARM)     power_d = 1'b1;
    else if (state_q != ST_IDLE && state_d == ST_IDLE && !cfg_keep_powered)
                                     power_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= ST_IDLE;
      warm_q       <= '0;
      dll_en_q     <= 1'b0;
      locked_q     <= 1'b0;
      power_q      <= 1'b0;
      calibrated_q <= 1'b0;
      by_ref_q     <= 1'b0;
      done_q       <= 1'b0;
      tout_q       <= 1'b0;
      p_q          <= '0;
      n_q          <= '0;
    end else begin
      state_q  <= state_d;
      warm_q   <= warm_d;
      dll_en_q <= dll_en_d;
      locked_q <= dll_en_d && dll_lock;
      power_q  <= power_d;
      if (cmd_dll_off)  calibrated_q <= 1'b0;
      else if (cal_ok)  calibrated_q <= 1'b1;
      if (state_q == ST_IDLE && state_d == ST_LOCKW)
        by_ref_q <= ref_hit && !cmd_start_cal;
      if (cal_ok) begin
        p_q <= cal_p_in;
        n_q <= cal_n_in;
      end
      if (cal_ok && by_ref_q) done_q <= 1'b1;
      else if (stat_rd)       done_q <= 1'b0;
      if (abort_c)            tout_q <= 1'b1;
      else if (stat_rd)       tout_q <= 1'b0;
    end
  end

  assign dll_enable        = dll_en_q;
  assign stat_locked       = locked_q;
  assign cal_power         = power_q;
  assign cal_req           = (state_q == ST_REQ);
  assign stat_cal_busy     = (state_q != ST_IDLE);
  assign stat_refresh_done = done_q;
  assign stat_timeout      = tout_q;
  assign code_p            = cfg_force_codes ? cfg_force_p : p_q;
  assign code_n            = cfg_force_codes ? cfg_force_n : n_q;

  // R2
  off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_dll_off |=> (!dll_enable && !stat_locked && !cal_power && !stat_cal_busy));
  // R4
  req_powered_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cal_req |-> (cal_power && stat_cal_busy));
  // R10
  refresh_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_refresh_done) |-> $past(stat_cal_busy));
  // R11
  timeout_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_timeout) |-> !stat_cal_busy);
endmodule

// File: tb/test_dll_cal_seq.sv
module test_dll_cal_seq;
  logic clk = 0, rst_n = 0;
  logic cmd_dll_on = 0, cmd_dll_off = 0, cmd_start_cal = 0;
  logic cfg_keep_powered = 0;
  logic [2:0] cfg_clk_div = 3'd2;
  logic [8:0] cfg_warm_cycles = 9'd10;
  logic [31:0] cfg_refresh_period = 0;
  logic cfg_force_codes = 0;
  logic [3:0] cfg_force_p = 0, cfg_force_n = 0;
  logic [15:0] cfg_timeout = 16'd2000;
  logic stat_rd = 0;
  logic dll_enable, dll_lock, cal_power, cal_clk_pulse, cal_req;
  logic cal_ack = 0;
  logic [3:0] cal_p_in = 0, cal_n_in = 0, code_p, code_n;
  logic stat_locked, stat_cal_busy, stat_refresh_done, stat_timeout;

  int checks = 0, fails = 0, cycles = 0;
  logic [2:0] lock_pipe = 0;
  logic lock_kill = 0, ack_block = 0;
  int ack_delay = 2, ack_wait = 0;
  logic [3:0] exp_p = 0, exp_n = 0;

  always #4 clk = ~clk;

  dll_cal_seq i_dll_cal_seq (.*);

  // loop model: locks three cycles after enable
  always @(posedge clk) lock_pipe <= {lock_pipe[1:0], dll_enable};
  assign dll_lock = lock_pipe[2] && !lock_kill;

  // calibration cell model
  always @(negedge clk) begin
    if (cal_ack) begin
      cal_ack = 0; ack_wait = 0;
    end else if (cal_req && !ack_block) begin
      if (ack_wait >= ack_delay) begin
        cal_p_in = 4'($urandom); cal_n_in = 4'($urandom);
        exp_p = cal_p_in; exp_n = cal_n_in;
        cal_ack = 1;
      end else ack_wait++;
    end else ack_wait = 0;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic int exp_pre(input int warm, input logic powered);
    return powered ? 1 : warm + 2;
  endfunction

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // pulse start, return cycles of busy before request
  task automatic start_and_measure(output int pre);
    @(negedge clk); cmd_start_cal = 1;
    @(negedge clk); cmd_start_cal = 0;
    pre = 0;
    while (!cal_req) begin
      if (stat_cal_busy) pre++;
      @(negedge clk);
    end
  endtask

  task automatic wait_idle();
    while (stat_cal_busy) @(negedge clk);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int pre, gap, w, t0, t1;
    logic pw;
    void'($urandom(32'd4242));
    cyc(3);
    // R1 during reset and first cycle after
    chk("R1 busy/req/power in reset", {stat_cal_busy, cal_req, cal_power, dll_enable}, 0);
    rst_n = 1;
    cyc(1);
    chk("R1 flags", {stat_locked, stat_refresh_done, stat_timeout, cal_clk_pulse}, 0);
    chk("R1 codes", {code_p, code_n}, 0);

    // R2 off wins over on
    cmd_dll_on = 1; cmd_dll_off = 1; cyc(1); cmd_dll_on = 0; cmd_dll_off = 0;
    chk("R2 off wins", dll_enable, 0);

    // R3 on and start together
    cmd_dll_on = 1; cmd_start_cal = 1; cyc(1); cmd_dll_on = 0; cmd_start_cal = 0;
    chk("R2 enable after on", dll_enable, 1);
    chk("R3 busy waiting for lock", {stat_cal_busy, stat_locked}, 2'b10);
    wait_idle();
    chk("R3 bring-up locked and idle", {stat_locked, stat_cal_busy}, 2'b10);
    chk("R7 codes after bring-up", {code_p, code_n}, {exp_p, exp_n});
    chk("R5 power off without keep", cal_power, 0);

    // R4 warm-up window, random lengths
    for (int i = 0; i < 5; i++) begin
      w = (i == 0) ? 0 : int'($urandom_range(40, 1));
      cfg_warm_cycles = 9'(w);
      ack_delay = int'($urandom_range(5, 0));
      start_and_measure(pre);
      chk("R4 warm-up request delay", pre, exp_pre(w, 1'b0));
      wait_idle();
      chk("R7 captured codes", {code_p, code_n}, {exp_p, exp_n});
    end

    // R5 keep powered
    cfg_keep_powered = 1; cfg_warm_cycles = 9'd7;
    start_and_measure(pre); wait_idle();
    chk("R5 first run warms", pre, exp_pre(7, 1'b0));
    chk("R5 power held", cal_power, 1);
    pw = cal_power;
    start_and_measure(pre); wait_idle();
    chk("R5 second run skips warm-up", pre, exp_pre(7, pw));

    // R6 strobe period for every divider
    for (int d = 0; d < 8; d++) begin
      cfg_clk_div = 3'(d);
      cyc(20);
      while (!cal_clk_pulse) @(negedge clk);
      t0 = cycles; @(negedge clk);
      while (!cal_clk_pulse) @(negedge clk);
      t1 = cycles;
      chk("R6 strobe period", t1 - t0, d + 1);
    end

    // R8 forced codes
    cfg_force_codes = 1;
    for (int i = 0; i < 3; i++) begin
      cfg_force_p = 4'($urandom); cfg_force_n = 4'($urandom);
      cyc(1);
      chk("R8 forced codes", {code_p, code_n}, {cfg_force_p, cfg_force_n});
    end
    start_and_measure(pre); wait_idle();
    chk("R8 forced during run", {code_p, code_n}, {cfg_force_p, cfg_force_n});
    cfg_force_codes = 0; cyc(1);
    chk("R8 release shows captured", {code_p, code_n}, {exp_p, exp_n});

    // R9 / R10 refresh
    cfg_keep_powered = 0;
    for (int i = 0; i < 3; i++) begin
      w = int'($urandom_range(60, 1));
      @(negedge clk); cmd_start_cal = 1;
      @(negedge clk); cmd_start_cal = 0; cfg_refresh_period = 32'(w);
      wait_idle();
      chk("R10 manual run leaves flag", stat_refresh_done, 0);
      gap = 0;
      while (!stat_cal_busy) begin gap++; @(negedge clk); end
      chk("R9 refresh idle gap", gap, w);
      cfg_refresh_period = 0;
      wait_idle();
      chk("R10 refresh done set", stat_refresh_done, 1);
      chk("R7 refresh codes", {code_p, code_n}, {exp_p, exp_n});
      stat_rd = 1; cyc(1); stat_rd = 0;
      chk("R10 cleared by read", stat_refresh_done, 0);
    end
    gap = 0;
    for (int k = 0; k < 300; k++) begin
      if (stat_cal_busy) gap++;
      @(negedge clk);
    end
    chk("R9 zero period never runs", gap, 0);

    // R11 watchdog on lock wait
    lock_kill = 1; cyc(3);
    chk("R2 lock follows input", stat_locked, 0);
    cfg_timeout = 16'd25;
    @(negedge clk); cmd_start_cal = 1;
    @(negedge clk); cmd_start_cal = 0;
    gap = 0;
    while (stat_cal_busy) begin gap++; @(negedge clk); end
    chk("R11 busy length equals limit", gap, 25);
    chk("R11 timeout flag", stat_timeout, 1);
    cyc(3);
    chk("R11 flag sticky", stat_timeout, 1);
    stat_rd = 1; cyc(1); stat_rd = 0;
    chk("R11 cleared by read", stat_timeout, 0);
    // R11 watchdog on ack wait
    lock_kill = 0; cyc(3); ack_block = 1; cfg_keep_powered = 1; cfg_warm_cycles = 9'd2;
    start_and_measure(pre);
    wait_idle();
    chk("R11 ack wait aborted", {stat_timeout, cal_req}, 2'b10);
    stat_rd = 1; cyc(1); stat_rd = 0;
    ack_block = 0; cfg_timeout = 0;

    // R2 abort by loop off during request
    ack_block = 1;
    start_and_measure(pre);
    cyc(4);
    cmd_dll_off = 1; cyc(1); cmd_dll_off = 0;
    chk("R2 off aborts run", {stat_cal_busy, cal_req, cal_power}, 0);
    chk("R2 off drops lock and enable", {stat_locked, dll_enable}, 0);
    ack_block = 0;
    gap = 0;
    for (int k = 0; k < 30; k++) begin
      if (cal_clk_pulse) gap++;
      @(negedge clk);
    end
    chk("R6 no strobe while unpowered", gap, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule